// File: doc/BRIEF.md
# Parallel Synchronous Capture Port

This block receives a stream from an external transmitter that drives a data bus, a strobe clock and optional handshake lines. The strobe clock, the handshake inputs and the data bus are brought into the system clock domain through synchronizer flops. A strobe edge is detected there, and the rising or falling edge is chosen at run time. On every accepted edge the block takes either one byte or a 16-bit halfword. The bytes are packed low to high into 32-bit words, and each complete word goes into a small word FIFO.

Software reaches the block through a simple select/write/address register port. It sets the edge, the handshake mode and the polarities, and it watches two fill flags. It pops words through a data register. An overrun occurs when a sample arrives while the FIFO is full, and an underrun occurs when the data register is read while the FIFO is empty. Either one sets a sticky flag that can be masked onto an interrupt line.

A 3-bit handshake mode chooses how the two handshake lines are used: neither, a ready output only, a valid input only, or one of those functions moved onto the other line. Each function keeps its own polarity bit.

Top module: `parsync_rx`

## Requirements
- R1: After reset the control register (0x00), status (0x04), raw flag (0x08) and interrupt enable (0x0C) read 0, `irq` is 0 and neither handshake pin output is enabled.
- R2: Control bit 5 picks the capture edge of `pclk_in`: 0 takes a sample on a falling edge and 1 on a rising edge. Each chosen edge gives exactly one sample while the block is enabled.
- R3: With handshake mode 1 (control bits 20:18), `rdy_pin_oe` is 1 and `rdy_pin_o` shows readiness. Readiness is true while the block is enabled and the FIFO is not full. Control bit 8 = 1 drives a high level for ready, and 0 drives a low level for ready.
- R4: With handshake mode 2, `vld_pin_i` qualifies samples. Control bit 6 = 1 means high is valid and 0 means low is valid. A sample taken while the line is not valid is discarded.
- R5: Mode 5 drives the ready function on `vld_pin_o` (`vld_pin_oe` = 1, `rdy_pin_oe` = 0) and keeps polarity bit 8. Mode 6 reads the valid function from `rdy_pin_i` with polarity bit 6 and ignores `vld_pin_i`. Modes 0, 3, 4 and 7 enable no pin output and accept every sample.
- R6: Width field bits 11:10 = 3 takes 16 bits per edge, and `pdata_in[7:0]` is packed before `pdata_in[15:8]`. Any other value takes only `pdata_in[7:0]`.
- R7: Reading the data register (0x28) returns the oldest FIFO word, with the earliest byte in bits 7:0 and later bytes filling upward. Each read pops one word.
- R8: Status bit 2 is 1 when the FIFO holds at least one full word. Status bit 3 is 1 when at least one byte is held, whether in the FIFO or in a partly packed word.
- R9: The FIFO holds 8 words. A valid sample that arrives while it is full is dropped and sets raw flag bit 1 (0x08). A data read while the FIFO is empty returns 0 and also sets that flag.
- R10: Raw flag bit 1 stays set until bit 1 of the clear register (0x14) is written with 1. Writes to 0x08 have no effect.
- R11: Bit 1 of 0x10 reads 1 exactly when raw flag bit 1 and enable bit 1 (0x0C) are both set, and `irq` follows that bit.
- R12: Control bit 14 enables capture. While it is 0, the FIFO and any partly packed word are discarded.
- R13: While bit 14 is 1, a write to the control register changes only bit 14. All other control fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_in | input | 1 | External strobe clock |
| pdata_in | input | 16 | External data bus |
| vld_pin_i | input | 1 | Valid line, input side |
| vld_pin_o | output | 1 | Valid line output (ready function in mode 5) |
| vld_pin_oe | output | 1 | Valid line output enable |
| rdy_pin_i | input | 1 | Ready line, input side (valid function in mode 6) |
| rdy_pin_o | output | 1 | Ready line output |
| rdy_pin_oe | output | 1 | Ready line output enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Masked overrun/underrun interrupt |

## Verification
The bench runs both edge choices under both capture widths. It puts junk in the upper data byte during byte mode, so a design that chose the wrong edge, counted an edge twice or packed the wrong half would return a scrambled word. It fills the FIFO to its limit and offers one more sample: a design that stored it would corrupt the oldest word, and one that forgot to flag it would leave the raw bit at 0. A read from an empty FIFO must give the underrun flag and a zero word. In both remapped handshake modes the bench checks that the function appears on the other line with the right polarity. It writes control fields while the block is enabled, and a design that accepted those writes would change the capture edge in mid-stream.

// File: rtl/parsync_pkg.sv
package parsync_pkg;

  localparam int REG_W = 32;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_RAW  = 8'h08;
  localparam logic [7:0] OFS_IEN  = 8'h0C;
  localparam logic [7:0] OFS_MSK  = 8'h10;
  localparam logic [7:0] OFS_CLR  = 8'h14;
  localparam logic [7:0] OFS_DATA = 8'h28;

  // control bit positions
  localparam int B_CKPOL  = 5;
  localparam int B_VPOL   = 6;
  localparam int B_RPOL   = 8;
  localparam int B_WID_LO = 10;
  localparam int B_EN     = 14;
  localparam int B_HS_LO  = 18;

  // flag and status bit positions
  localparam int B_OVR  = 1;
  localparam int B_RDY4 = 2;
  localparam int B_RDY1 = 3;

  // handshake modes
  localparam logic [2:0] HS_OFF        = 3'd0;
  localparam logic [2:0] HS_RDY        = 3'd1;
  localparam logic [2:0] HS_VLD        = 3'd2;
  localparam logic [2:0] HS_RDY_ON_VLD = 3'd5;
  localparam logic [2:0] HS_VLD_ON_RDY = 3'd6;

  localparam logic [1:0] WID_HALF = 2'd3;

  typedef struct packed {
    logic [2:0] hs;
    logic       en;
    logic [1:0] wid;
    logic       rpol;
    logic       vpol;
    logic       ckpol;
  } ctrl_t;

endpackage

// File: rtl/parsync_sync.sv
module parsync_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/parsync_pack.sv
module parsync_pack #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int CNT_W  = $clog2(LANES) + 1,
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                take,
  input  logic                wide,
  input  logic [2*BYTE_W-1:0] din,
  output logic                word_vld,
  output logic [WORD_W-1:0]   word,
  output logic [CNT_W-1:0]    fill
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_sum;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              we;
    logic [BYTE_W-1:0] lane_d, lane_q;

    always_comb begin
      we     = 1'b0;
      lane_d = din[BYTE_W-1:0];
      if (take) begin
        if (CNT_W'(i) == cnt_q) begin
          we = 1'b1;
        end else if (wide && (CNT_W'(i) == cnt_q + 1'b1)) begin
          we     = 1'b1;
          lane_d = din[2*BYTE_W-1:BYTE_W];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lane_q <= '0;
      else if (we) lane_q <= lane_d;
    end

    // completed word includes the bytes landing this cycle
    assign word[i*BYTE_W +: BYTE_W] = we ? lane_d : lane_q;
  end

  always_comb begin
    cnt_sum  = {1'b0, cnt_q} + (wide ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
    cnt_d    = cnt_q;
    word_vld = 1'b0;
    if (flush) begin
      cnt_d = '0;
    end else if (take) begin
      if (cnt_sum >= (CNT_W+1)'(LANES)) begin
        word_vld = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fill = cnt_q;

endmodule

// File: rtl/parsync_fifo.sv
module parsync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = bump(wp_q);
      if (do_pop)  rp_d = bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/parsync_rx.sv
module parsync_rx
  import parsync_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int LANES       = 4,
  parameter int FIFO_DEPTH  = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pclk_in,
  input  logic [2*BYTE_W-1:0] pdata_in,
  input  logic                vld_pin_i,
  output logic                vld_pin_o,
  output logic                vld_pin_oe,
  input  logic                rdy_pin_i,
  output logic                rdy_pin_o,
  output logic                rdy_pin_oe,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                irq
);

  localparam int PIN_W    = 2 * BYTE_W;
  localparam int WORD_W   = BYTE_W * LANES;
  localparam int FILL_W   = $clog2(LANES) + 1;
  localparam int FCNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int BUNDLE_W = PIN_W + 3;

  // ---------------- register state ----------------
  ctrl_t ctrl_q, ctrl_d;
  logic  ier_q, ier_d;
  logic  ris_q, ris_d;

  // ---------------- bus decode ----------------
  logic rd_en, wr_en;
  logic hit_ctrl, hit_stat, hit_raw, hit_ien, hit_msk, hit_clr, hit_data;
  logic clr_hit, pop_req, underrun;

  assign rd_en    = bus_sel && !bus_wr;
  assign wr_en    = bus_sel && bus_wr;
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_raw  = (bus_addr == ADDR_W'(OFS_RAW));
  assign hit_ien  = (bus_addr == ADDR_W'(OFS_IEN));
  assign hit_msk  = (bus_addr == ADDR_W'(OFS_MSK));
  assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign clr_hit  = wr_en && hit_clr && bus_wdata[B_OVR];

  // ---------------- input synchronization ----------------
  logic [BUNDLE_W-1:0] raw_in, sync_out;
  logic                s_pclk, s_vld, s_rdy;
  logic [PIN_W-1:0]    s_data;
  logic                pclk_prev_q;

  assign raw_in = {pclk_in, vld_pin_i, rdy_pin_i, pdata_in};

  parsync_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign {s_pclk, s_vld, s_rdy, s_data} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_prev_q <= 1'b0;
    else        pclk_prev_q <= s_pclk;
  end

  // ---------------- edge and qualifier ----------------
  logic edge_rise, edge_fall, edge_hit;
  logic use_vld, vld_level, vld_ok;
  logic sample, take, overrun;

  assign edge_rise = s_pclk && !pclk_prev_q;
  assign edge_fall = !s_pclk && pclk_prev_q;
  assign edge_hit  = ctrl_q.ckpol ? edge_rise : edge_fall;

  always_comb begin
    use_vld   = 1'b0;
    vld_level = s_vld;
    case (ctrl_q.hs)
      HS_VLD:        use_vld = 1'b1;
      HS_VLD_ON_RDY: begin
        use_vld   = 1'b1;
        vld_level = s_rdy;
      end
      default:       use_vld = 1'b0;
    endcase
  end

  assign vld_ok  = !use_vld || (vld_level == ctrl_q.vpol);
  assign sample  = ctrl_q.en && edge_hit && vld_ok;

  // ---------------- packing and storage ----------------
  logic              fifo_full, fifo_empty, push;
  logic [WORD_W-1:0] packed_word, head;
  logic [FILL_W-1:0] fill;
  logic [FCNT_W-1:0] fcnt;
  logic              flush, pop;

  assign take     = sample && !fifo_full;
  assign overrun  = sample && fifo_full;
  assign flush    = !ctrl_q.en;
  assign pop_req  = rd_en && hit_data;
  assign pop      = pop_req && !fifo_empty;
  assign underrun = pop_req && fifo_empty;

  parsync_pack #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .take     (take),
    .wide     (ctrl_q.wid == WID_HALF),
    .din      (s_data),
    .word_vld (push),
    .word     (packed_word),
    .fill     (fill)
  );

  parsync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (packed_word),
    .pop       (pop),
    .head      (head),
    .count     (fcnt),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  // ---------------- handshake outputs ----------------
  logic ready, rdy_level;

  assign ready      = ctrl_q.en && !fifo_full;
  assign rdy_level  = ctrl_q.rpol ? ready : !ready;
  assign rdy_pin_oe = (ctrl_q.hs == HS_RDY);
  assign vld_pin_oe = (ctrl_q.hs == HS_RDY_ON_VLD);
  assign rdy_pin_o  = rdy_pin_oe && rdy_level;
  assign vld_pin_o  = vld_pin_oe && rdy_level;

  // ---------------- register next state ----------------
  logic ovr_set;
  assign ovr_set = overrun || underrun;

  always_comb begin
    ctrl_d = ctrl_q;
    ier_d  = ier_q;
    ris_d  = ris_q;
    if (wr_en && hit_ctrl) begin
      if (ctrl_q.en) begin
        ctrl_d.en = bus_wdata[B_EN];
      end else begin
        ctrl_d.ckpol = bus_wdata[B_CKPOL];
        ctrl_d.vpol  = bus_wdata[B_VPOL];
        ctrl_d.rpol  = bus_wdata[B_RPOL];
        ctrl_d.wid   = bus_wdata[B_WID_LO +: 2];
        ctrl_d.en    = bus_wdata[B_EN];
        ctrl_d.hs    = bus_wdata[B_HS_LO +: 3];
      end
    end
    if (wr_en && hit_ien) ier_d = bus_wdata[B_OVR];
    if (ovr_set)          ris_d = 1'b1;
    else if (clr_hit)     ris_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ier_q  <= 1'b0;
      ris_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ier_q  <= ier_d;
      ris_q  <= ris_d;
    end
  end

  // ---------------- read mux ----------------
  logic mis;
  assign mis = ris_q && ier_q;
  assign irq = mis;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (hit_ctrl) begin
        bus_rdata[B_CKPOL]        = ctrl_q.ckpol;
        bus_rdata[B_VPOL]         = ctrl_q.vpol;
        bus_rdata[B_RPOL]         = ctrl_q.rpol;
        bus_rdata[B_WID_LO +: 2]  = ctrl_q.wid;
        bus_rdata[B_EN]           = ctrl_q.en;
        bus_rdata[B_HS_LO +: 3]   = ctrl_q.hs;
      end
      if (hit_stat) begin
        bus_rdata[B_RDY4] = !fifo_empty;
        bus_rdata[B_RDY1] = !fifo_empty || (fill != '0);
      end
      if (hit_raw) bus_rdata[B_OVR] = ris_q;
      if (hit_ien) bus_rdata[B_OVR] = ier_q;
      if (hit_msk) bus_rdata[B_OVR] = mis;
      if (hit_data && !fifo_empty) bus_rdata = REG_W'(head);
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, fcnt};

endmodule

// File: rtl/parsync_rx_chk.sv
module parsync_rx_chk #(
  parameter int FIFO_DEPTH = 8,
  localparam int FCNT_W    = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [2:0]        hs,
  input logic              rpol,
  input logic [FCNT_W-1:0] fcnt,
  input logic              fifo_full,
  input logic              push,
  input logic              ris,
  input logic              ier,
  input logic              clr_hit,
  input logic              ovr_set,
  input logic              rdy_pin_o,
  input logic              rdy_pin_oe,
  input logic              vld_pin_oe,
  input logic              irq
);

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FCNT_W'(FIFO_DEPTH)); // R9

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ris && !clr_hit) |=> ris); // R10

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !ovr_set) |=> !ris); // R10

  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fcnt == '0)); // R12

  AST_RDY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_pin_oe && fifo_full) |-> (rdy_pin_o == !rpol)); // R3

  AST_PIN_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vld_pin_oe, rdy_pin_oe})); // R5

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ier && ris)); // R11

  AST_RDY_MODE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pin_oe |-> (hs == 3'd1)); // R3

endmodule

bind parsync_rx parsync_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (ctrl_q.en),
  .hs         (ctrl_q.hs),
  .rpol       (ctrl_q.rpol),
  .fcnt       (fcnt),
  .fifo_full  (fifo_full),
  .push       (push),
  .ris        (ris_q),
  .ier        (ier_q),
  .clr_hit    (clr_hit),
  .ovr_set    (ovr_set),
  .rdy_pin_o  (rdy_pin_o),
  .rdy_pin_oe (rdy_pin_oe),
  .vld_pin_oe (vld_pin_oe),
  .irq        (irq)
);

// File: tb/parsync_rx_test.sv
module parsync_rx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pclk_in = 1'b0;
  logic [15:0] pdata_in = '0;
  logic        vld_pin_i = 1'b0;
  logic        rdy_pin_i = 1'b0;
  logic        vld_pin_o, vld_pin_oe, rdy_pin_o, rdy_pin_oe;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  parsync_rx uut (
    .clk(clk), .rst_n(rst_n), .pclk_in(pclk_in), .pdata_in(pdata_in),
    .vld_pin_i(vld_pin_i), .vld_pin_o(vld_pin_o), .vld_pin_oe(vld_pin_oe),
    .rdy_pin_i(rdy_pin_i), .rdy_pin_o(rdy_pin_o), .rdy_pin_oe(rdy_pin_oe),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {ckpol, wide, edges[2:0], d0, d1, d2, d3, expected word}
  localparam int NV = 4;
  localparam logic [100:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd4, 16'hA511, 16'hA522, 16'h5A33, 16'hFF44, 32'h44332211},
    {1'b0, 1'b0, 3'd4, 16'h77A1, 16'h00B2, 16'h12C3, 16'h34D4, 32'hD4C3B2A1},
    {1'b1, 1'b1, 3'd2, 16'h2211, 16'h4433, 16'h0000, 16'h0000, 32'h44332211},
    {1'b0, 1'b1, 3'd2, 16'hBEEF, 16'hDEAD, 16'h0000, 16'h0000, 32'hDEADBEEF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(input logic en, input logic ck, input logic vp,
                                          input logic rp, input logic wide, input logic [2:0] hs);
    return (32'(en) << 14) | (32'(ck) << 5) | (32'(vp) << 6) | (32'(rp) << 8) |
           ((wide ? 32'd3 : 32'd0) << 10) | (32'(hs) << 18);
  endfunction

  // one strobe period: both edges present, data steady around them
  task automatic pulse(input logic [15:0] d);
    @(negedge clk); pclk_in = 1'b0;
    repeat (3) @(negedge clk);
    pdata_in = d;
    repeat (4) @(negedge clk);
    pclk_in = 1'b1;
    repeat (6) @(negedge clk);
    pclk_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(8'h00, r); check("R1 ctrl", r, 32'h0);
    rd(8'h04, r); check("R1 status", r, 32'h0);
    rd(8'h08, r); check("R1 raw", r, 32'h0);
    rd(8'h0C, r); check("R1 ien", r, 32'h0);
    check("R1 irq/oe", {29'd0, irq, rdy_pin_oe, vld_pin_oe}, 32'h0);

    // table: R2 edges, R6 widths, R7 packing
    for (int v = 0; v < NV; v++) begin
      logic [100:0] e;
      logic [15:0]  dv [4];
      e = VEC[v];
      dv[0] = e[95:80]; dv[1] = e[79:64]; dv[2] = e[63:48]; dv[3] = e[47:32];
      wr(8'h00, mk_ctrl(1'b0, e[100], 1'b0, 1'b0, e[99], 3'd0));
      wr(8'h00, mk_ctrl(1'b1, e[100], 1'b0, 1'b0, e[99], 3'd0));
      for (int k = 0; k < int'(e[98:96]); k++) pulse(dv[k]);
      rd(8'h04, r); check($sformatf("R8 vec%0d status", v), r, 32'hC);
      rd(8'h28, r); check($sformatf("R2 R6 R7 vec%0d word", v), r, e[31:0]);
      wr(8'h00, 32'h0);
    end

    // R13: fields frozen while enabled
    wr(8'h00, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0));
    wr(8'h00, mk_ctrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2));
    rd(8'h00, r); check("R13 ctrl frozen", r, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0));
    // R8 partial word
    pulse(16'h0055);
    rd(8'h04, r); check("R8 one byte", r, 32'h8);
    wr(8'h00, 32'h0);
    // R12 flush of partial word
    rd(8'h04, r); check("R12 flushed", r, 32'h0);

    // R4 valid input, high active
    wr(8'h00, mk_ctrl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2));
    wr(8'h00, mk_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2));
    vld_pin_i = 1'b1; pulse(16'h0010); pulse(16'h0020);
    vld_pin_i = 1'b0; pulse(16'h0099);
    vld_pin_i = 1'b1; pulse(16'h0030); pulse(16'h0040);
    rd(8'h28, r); check("R4 qualified word", r, 32'h40302010);
    wr(8'h00, 32'h0);

    // R5 valid function read from ready line, low active
    wr(8'h00, mk_ctrl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6));
    wr(8'h00, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6));
    vld_pin_i = 1'b1; rdy_pin_i = 1'b0; pulse(16'h0001); pulse(16'h0002);
    vld_pin_i = 1'b0; rdy_pin_i = 1'b1; pulse(16'h00EE);
    vld_pin_i = 1'b1; rdy_pin_i = 1'b0; pulse(16'h0003); pulse(16'h0004);
    rd(8'h28, r); check("R5 remapped valid word", r, 32'h04030201);
    check("R5 no pin driven in mode 6", {30'd0, rdy_pin_oe, vld_pin_oe}, 32'h0);
    wr(8'h00, 32'h0);

    // R5 ready function on valid line, low active
    wr(8'h00, mk_ctrl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5));
    wr(8'h00, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5));
    @(negedge clk);
    check("R5 ready on valid line", {29'd0, vld_pin_oe, vld_pin_o, rdy_pin_oe}, 32'h4);
    wr(8'h00, 32'h0);

    // R3 ready output, fill to full, R9 overrun, R10/R11 flags
    wr(8'h00, mk_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1));
    wr(8'h00, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1));
    @(negedge clk);
    check("R3 ready high", {30'd0, rdy_pin_oe, rdy_pin_o}, 32'h3);
    for (int i = 0; i < 32; i++) pulse(16'(i));
    check("R3 full not ready", {30'd0, rdy_pin_oe, rdy_pin_o}, 32'h2);
    rd(8'h08, r); check("R9 no flag yet", r, 32'h0);
    pulse(16'h00AA);
    rd(8'h08, r); check("R9 overrun flag", r, 32'h2);
    check("R11 masked irq low", {31'd0, irq}, 32'h0);
    rd(8'h10, r); check("R11 masked reg off", r, 32'h0);
    wr(8'h0C, 32'h2);
    @(negedge clk);
    check("R11 irq", {31'd0, irq}, 32'h1);
    rd(8'h10, r); check("R11 masked reg", r, 32'h2);
    wr(8'h08, 32'h0);
    rd(8'h08, r); check("R10 raw write ignored", r, 32'h2);
    wr(8'h14, 32'h2);
    rd(8'h08, r); check("R10 cleared", r, 32'h0);
    check("R11 irq cleared", {31'd0, irq}, 32'h0);
    rd(8'h28, r); check("R9 oldest word kept", r, 32'h03020100);
    @(negedge clk);
    check("R3 ready again", {30'd0, rdy_pin_oe, rdy_pin_o}, 32'h3);
    for (int i = 1; i < 7; i++) rd(8'h28, r);
    rd(8'h28, r); check("R7 last word", r, 32'h1F1E1D1C);
    rd(8'h28, r); check("R9 underrun data", r, 32'h0);
    rd(8'h08, r); check("R9 underrun flag", r, 32'h2);
    wr(8'h14, 32'h2);

    // R12 flush of full words
    pulse(16'h0001); pulse(16'h0002); pulse(16'h0003); pulse(16'h0004);
    rd(8'h04, r); check("R12 word before disable", r, 32'hC);
    wr(8'h00, 32'h0);
    rd(8'h04, r); check("R12 empty after disable", r, 32'h0);
    rd(8'h00, r); check("R13 disable keeps fields", r, mk_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule